// File: doc/BRIEF.md
# Configuration Memory Error Classifier

This block sits behind a configuration-memory integrity checker. The checker captures two error-report fields, one from its column check and one from its frame check. Each field carries a 3-bit type code and a 5-bit bit position. For every captured report, the block decides whether the upset can be repaired. Any field that cannot be repaired has its type rewritten to the all-ones code. When the event is repairable and scrubbing is enabled, the block issues a one-cycle scrub request.

The block also watches the raw error line from the checker. Each detection normally shows up as a short pulse. When the line rises for the second time since the last repairable result and then stays high, the checker has locked up. The block latches a dead flag, and only a reset (standing in for full reconfiguration) clears it. While the dead flag is set, every report is forced to uncorrectable, with both types at all-ones.

Top module: `cram_err_classifier`

## Requirements
- R1: A frame field is uncorrectable when its type is 3'b111, or its type is 3'b010 with position 5'h1F, or its type is 3'b011 with a position other than 5'h1F. Any other non-zero frame field is correctable. This includes type 3'b001, type 3'b010 with position not 5'h1F, and type 3'b011 with position 5'h1F.
- R2: A column field is uncorrectable when its type is 3'b111, or its type is 3'b010 with position 5'h1F, or its type is 3'b011 with a position other than 5'h00. Any other non-zero column field is correctable.
- R3: A field whose type and position are both zero did not report, and it takes no part in the decision. A report with only one populated field is classified by that field alone. A report with neither field populated gives correctable_o = 0 and both types 3'b000.
- R4: When both fields are populated, correctable_o is 1 only if neither field meets its own uncorrectable condition.
- R5: col_type_o and frm_type_o show 3'b111 for a field that is uncorrectable. Otherwise they show the input type unchanged.
- R6: res_valid_o is high for exactly one cycle, one clock after each cycle in which rpt_valid_i is sampled high. The result outputs are registered and hold their values until the next report.
- R7: scrub_req_o pulses together with res_valid_o only when the result is correctable and scrub_en_i was high together with rpt_valid_i. It never pulses otherwise.
- R8: dead_o rises after the error line has been sampled high for HOLD_CYC consecutive cycles (default 16). This happens only if that high run began with the second or a later rising edge counted since reset or since the last correctable result. A high run that began with the first such edge, or a run shorter than HOLD_CYC, never sets dead_o.
- R9: Once dead_o is high, it stays high until reset. Every result produced while it is high has both types at 3'b111, correctable_o = 0 and no scrub request.
- R10: A correctable result clears the rising-edge count, so the next rising edge counts as the first.
- R11: After reset, res_valid_o, correctable_o, scrub_req_o and dead_o are 0, and both type outputs are 3'b000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset (models reconfiguration) |
| rpt_valid_i | input | 1 | Report fields are valid this cycle |
| col_type_i | input | 3 | Column-check type code |
| col_pos_i | input | 5 | Column-check bit position |
| frm_type_i | input | 3 | Frame-check type code |
| frm_pos_i | input | 5 | Frame-check bit position |
| err_line_i | input | 1 | Raw error line from the integrity checker |
| scrub_en_i | input | 1 | Internal scrubbing enable |
| res_valid_o | output | 1 | One-cycle result strobe |
| correctable_o | output | 1 | Result is repairable |
| col_type_o | output | 3 | Normalised column type |
| frm_type_o | output | 3 | Normalised frame type |
| scrub_req_o | output | 1 | One-cycle scrub request |
| dead_o | output | 1 | Latched dead-state flag |

## Verification
Classification results, the scrub request and res_valid_o are due on the first rising edge after the edge that samples rpt_valid_i. The bench drives each report on a falling edge and reads the results just after the next rising edge. It then checks one edge later that the strobes have dropped and the held values have not changed. dead_o is due on the HOLD_CYC-th rising edge that samples the error line high, counting from the first high sample. The bench checks dead_o is still low one edge before that and high exactly on it. It also checks that runs of HOLD_CYC-1 high samples, or runs that began with the first counted rising edge, never set the flag.

// File: rtl/cram_err_pkg.sv
package cram_err_pkg;
  localparam int TYPE_W = 3;
  localparam int POS_W  = 5;
  localparam logic [TYPE_W-1:0] TYPE_UNC = 3'b111;
  localparam logic [TYPE_W-1:0] TYPE_DBL = 3'b010;
  localparam logic [TYPE_W-1:0] TYPE_ODD = 3'b011;

  typedef enum logic {KIND_COL = 1'b0, KIND_FRM = 1'b1} fld_kind_e;

  typedef struct packed {
    logic [TYPE_W-1:0] typ;
    logic [POS_W-1:0]  pos;
  } fld_t;
endpackage

// File: rtl/cram_field_chk.sv
module cram_field_chk
  import cram_err_pkg::*;
#(
  parameter fld_kind_e KIND = KIND_FRM
) (
  input  fld_t              fld_i,
  output logic              used_o,
  output logic              unc_o,
  output logic [TYPE_W-1:0] norm_o
);
  logic pos_ones, pos_zero, odd_bad;

  assign pos_ones = &fld_i.pos;
  assign pos_zero = ~|fld_i.pos;

  // the odd-type position rule is the only difference between checks
  generate
    if (KIND == KIND_FRM) begin : g_frm
      assign odd_bad = ~pos_ones;
    end else begin : g_col
      assign odd_bad = ~pos_zero;
    end
  endgenerate

  assign used_o = |fld_i;
  assign unc_o  = used_o & ((fld_i.typ == TYPE_UNC) |
                            ((fld_i.typ == TYPE_DBL) & pos_ones) |
                            ((fld_i.typ == TYPE_ODD) & odd_bad));
  assign norm_o = unc_o ? TYPE_UNC : fld_i.typ;
endmodule

// File: rtl/cram_dead_det.sv
module cram_dead_det #(
  parameter int HOLD_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic err_line_i,
  input  logic clr_i,
  output logic dead_set_o,
  output logic dead_o
);
  localparam int CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] HOLD_M1 = CW'(HOLD_CYC - 1);
  localparam logic [CW-1:0] HOLD_V  = CW'(HOLD_CYC);

  logic          err_q;
  logic [1:0]    edge_cnt;
  logic [CW-1:0] high_cnt;
  logic          rise;
  logic [1:0]    edges_now;

  assign rise      = err_line_i & ~err_q;
  assign edges_now = (edge_cnt == 2'd2) ? 2'd2 : edge_cnt + {1'b0, rise};
  assign dead_set_o = err_line_i & (high_cnt == HOLD_M1) & (edges_now == 2'd2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q    <= 1'b0;
      edge_cnt <= 2'd0;
      high_cnt <= '0;
      dead_o   <= 1'b0;
    end else begin
      err_q    <= err_line_i;
      edge_cnt <= clr_i ? {1'b0, rise} : edges_now;
      if (!err_line_i)              high_cnt <= '0;
      else if (high_cnt != HOLD_V)  high_cnt <= high_cnt + 1'b1;
      if (dead_set_o) dead_o <= 1'b1;
    end
  end

  // R9
  dead_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dead_o |=> dead_o);
  // R8
  dead_on_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dead_o) |-> $past(err_line_i));
endmodule

// File: rtl/cram_err_classifier.sv
module cram_err_classifier
  import cram_err_pkg::*;
#(
  parameter int HOLD_CYC = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rpt_valid_i,
  input  logic [2:0] col_type_i,
  input  logic [4:0] col_pos_i,
  input  logic [2:0] frm_type_i,
  input  logic [4:0] frm_pos_i,
  input  logic       err_line_i,
  input  logic       scrub_en_i,
  output logic       res_valid_o,
  output logic       correctable_o,
  output logic [2:0] col_type_o,
  output logic [2:0] frm_type_o,
  output logic       scrub_req_o,
  output logic       dead_o
);
  logic              col_used, col_unc, frm_used, frm_unc;
  logic [TYPE_W-1:0] col_norm, frm_norm;
  logic              dead_set, dead_now, corr_d, clr_edges;

  cram_field_chk #(.KIND(KIND_COL)) u_col (
    .fld_i  ({col_type_i, col_pos_i}),
    .used_o (col_used),
    .unc_o  (col_unc),
    .norm_o (col_norm)
  );

  cram_field_chk #(.KIND(KIND_FRM)) u_frm (
    .fld_i  ({frm_type_i, frm_pos_i}),
    .used_o (frm_used),
    .unc_o  (frm_unc),
    .norm_o (frm_norm)
  );

  assign dead_now  = dead_o | dead_set;
  assign corr_d    = (col_used | frm_used) & ~col_unc & ~frm_unc & ~dead_now;
  assign clr_edges = rpt_valid_i & corr_d;

  cram_dead_det #(.HOLD_CYC(HOLD_CYC)) u_dead (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .err_line_i (err_line_i),
    .clr_i      (clr_edges),
    .dead_set_o (dead_set),
    .dead_o     (dead_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o   <= 1'b0;
      correctable_o <= 1'b0;
      col_type_o    <= '0;
      frm_type_o    <= '0;
      scrub_req_o   <= 1'b0;
    end else begin
      res_valid_o <= rpt_valid_i;
      scrub_req_o <= rpt_valid_i & corr_d & scrub_en_i;
      if (rpt_valid_i) begin
        correctable_o <= corr_d;
        col_type_o    <= dead_now ? TYPE_UNC : col_norm;
        frm_type_o    <= dead_now ? TYPE_UNC : frm_norm;
      end
    end
  end

  // R6
  res_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rpt_valid_i |=> res_valid_o);
  // R6
  res_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rpt_valid_i |=> !res_valid_o && $stable(col_type_o) && $stable(frm_type_o));
  // R7
  scrub_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scrub_req_o |-> res_valid_o && correctable_o);
  // R9
  dead_force_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && dead_o |-> col_type_o == 3'b111 && frm_type_o == 3'b111 && !correctable_o);
  // R5
  corr_type_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && correctable_o |-> col_type_o != 3'b111 && frm_type_o != 3'b111);
endmodule

// File: tb/cram_err_classifier_bench.sv
module cram_err_classifier_bench;
  localparam int HOLD = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rpt_valid = 1'b0, err_line = 1'b0, scrub_en = 1'b0;
  logic [2:0] col_t = '0, frm_t = '0;
  logic [4:0] col_p = '0, frm_p = '0;
  logic res_valid, correctable, scrub_req, dead;
  logic [2:0] col_to, frm_to;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  cram_err_classifier #(.HOLD_CYC(HOLD)) u_cram_err_classifier (
    .clk_i(clk), .rst_ni(rst_n), .rpt_valid_i(rpt_valid),
    .col_type_i(col_t), .col_pos_i(col_p), .frm_type_i(frm_t), .frm_pos_i(frm_p),
    .err_line_i(err_line), .scrub_en_i(scrub_en),
    .res_valid_o(res_valid), .correctable_o(correctable),
    .col_type_o(col_to), .frm_type_o(frm_to),
    .scrub_req_o(scrub_req), .dead_o(dead));

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit unc_of(bit frm, logic [2:0] t, logic [4:0] p);
    if ({t, p} == 8'h00) return 1'b0;
    if (t == 3'b111) return 1'b1;
    if (t == 3'b010 && p == 5'h1F) return 1'b1;
    if (t == 3'b011) return frm ? (p != 5'h1F) : (p != 5'h00);
    return 1'b0;
  endfunction

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; err_line = 1'b0; rpt_valid = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  // report with expected values derived from R1..R5, R7, R9
  task automatic report(string req, logic [2:0] ct, logic [4:0] cp,
                        logic [2:0] ft, logic [4:0] fp, bit en, bit is_dead);
    bit cu, fu, used, ec;
    logic [2:0] ect, eft;
    cu = unc_of(1'b0, ct, cp);
    fu = unc_of(1'b1, ft, fp);
    used = ({ct, cp} != 0) || ({ft, fp} != 0);
    ec = used && !cu && !fu && !is_dead;
    ect = (cu || is_dead) ? 3'b111 : ct;
    eft = (fu || is_dead) ? 3'b111 : ft;
    @(negedge clk);
    col_t = ct; col_p = cp; frm_t = ft; frm_p = fp; scrub_en = en; rpt_valid = 1'b1;
    @(posedge clk); #1;
    chk({req, " R6 valid"}, res_valid, 1);
    chk({req, " corr"}, correctable, ec);
    chk({req, " R5 col_type"}, col_to, ect);
    chk({req, " R5 frm_type"}, frm_to, eft);
    chk({req, " R7 scrub"}, scrub_req, ec && en);
    @(negedge clk); rpt_valid = 1'b0; col_t = '0; col_p = '0; frm_t = '0; frm_p = '0;
    @(posedge clk); #1;
    chk({req, " R6 drop"}, res_valid, 0);
    chk({req, " R7 drop"}, scrub_req, 0);
    chk({req, " R6 hold"}, col_to, ect);
  endtask

  task automatic hold_high(int n);
    @(negedge clk); err_line = 1'b1;
    repeat (n) @(negedge clk);
    err_line = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    #1;
    chk("R11 valid", res_valid, 0); chk("R11 corr", correctable, 0);
    chk("R11 scrub", scrub_req, 0); chk("R11 dead", dead, 0);
    chk("R11 types", {col_to, frm_to}, 0);
  endtask

  task automatic t_frame();
    report("R1 t1", 0, 0, 3'b001, 5'h03, 1, 0);
    report("R1 t2ok", 0, 0, 3'b010, 5'h1E, 1, 0);
    report("R1 t2bad", 0, 0, 3'b010, 5'h1F, 1, 0);
    report("R1 t3ok", 0, 0, 3'b011, 5'h1F, 1, 0);
    report("R1 t3bad", 0, 0, 3'b011, 5'h00, 1, 0);
    report("R1 t7", 0, 0, 3'b111, 5'h05, 1, 0);
  endtask

  task automatic t_column();
    report("R2 t3ok", 3'b011, 5'h00, 0, 0, 1, 0);
    report("R2 t3bad", 3'b011, 5'h1F, 0, 0, 1, 0);
    report("R2 t2bad", 3'b010, 5'h1F, 0, 0, 1, 0);
    report("R2 t2ok", 3'b010, 5'h04, 0, 0, 1, 0);
    report("R2 t7", 3'b111, 5'h00, 0, 0, 1, 0);
  endtask

  task automatic t_dual();
    report("R3 none", 0, 0, 0, 0, 1, 0);
    report("R4 both ok", 3'b001, 5'h02, 3'b010, 5'h01, 1, 0);
    report("R4 frm bad", 3'b001, 5'h02, 3'b011, 5'h02, 1, 0);
    report("R4 col bad", 3'b011, 5'h01, 3'b011, 5'h1F, 1, 0);
    report("R7 en off", 3'b001, 5'h02, 0, 0, 0, 0);
  endtask

  task automatic t_dead();
    do_reset();
    hold_high(2 * HOLD);
    chk("R8 first edge", dead, 0);
    report("R10 clear", 0, 0, 3'b001, 5'h01, 0, 0);
    hold_high(2 * HOLD);
    chk("R10 edge recount", dead, 0);
    hold_high(HOLD - 1);
    chk("R8 short run", dead, 0);
    @(negedge clk); err_line = 1'b1;
    repeat (HOLD - 1) @(posedge clk);
    #1 chk("R8 one early", dead, 0);
    @(posedge clk); #1 chk("R8 exact", dead, 1);
    @(negedge clk); err_line = 1'b0;
    repeat (8) @(negedge clk);
    chk("R9 sticky", dead, 1);
    report("R9 forced", 3'b001, 5'h01, 3'b001, 5'h01, 1, 1);
    do_reset();
    #1 chk("R9 reset clears", dead, 0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_frame();
    t_column();
    t_dual();
    t_dead();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule